// File: doc/BRIEF.md
# Prioritized Dual-Output Interrupt Controller

This block collects 32 interrupt request lines and drives two processor interrupt outputs. One output is a fast interrupt, the other a normal interrupt. Each line can be set to trigger on a rising edge or on a high level. Each line can also be masked, given a 5-bit priority, and routed to either output. A request sets a bit in a latched pending register. For each output, an arbiter picks the best unmasked pending line that is routed to that output. The number of that line appears in a per-output source register.

Software reaches the block through a single-cycle synchronous register port. Read data comes back one cycle after the request. A read of an output's source register also acknowledges the interrupt it reports, by clearing that line's pending bit. Pending bits can be cleared by writing 0 to them; writing 1 leaves a bit as it was. A read-only revision register identifies the block.

Register map (byte offsets):

| Offset | Register | Access |
|---|---|---|
| 0x00 | pending | write 0 clears a bit, write 1 keeps it |
| 0x04 | mask | read/write |
| 0x08 | trigger mode | read/write |
| 0x10 | IRQ source | read; a read with the valid flag set acknowledges |
| 0x14 | FIQ source | read; a read with the valid flag set acknowledges |
| 0x20 + 4·n | configuration of line n | read/write |
| 0xA8 | revision | read-only |

Top module: `intc_dual`

## Requirements
- R1: Each input line passes through a 2-stage synchronizer. A line that goes high before clock edge k is pending after edge k+2, and the outputs reflect it right after that edge.
- R2: Trigger-mode bit n (offset 0x08) chooses how line n is detected: 1 = rising edge, 0 = level. An edge-mode line latches once per rising edge and stays cleared after an acknowledge while its input is still high. A level-mode line sets its pending bit on every cycle that its synchronized input is high.
- R3: A write to the pending register (offset 0x00) clears each bit written 0 and keeps each bit written 1. When a hardware set and a software clear of the same bit fall in the same cycle, the bit ends up set.
- R4: Among the eligible lines of an output, the lowest priority value wins, with 0 the most urgent. On equal priority, the lowest line number wins. Priority is bits 4:0 of the line's configuration word at offset 0x20 + 4·n.
- R5: Bit 8 of a line's configuration word routes the line to the FIQ output (1) or the IRQ output (0). The two outputs are arbitrated independently.
- R6: A source register (IRQ at 0x10, FIQ at 0x14) reads as {valid at bit 31, zeros, winning line number in bits 4:0}. A read that returns valid clears that line's pending bit.
- R7: A mask bit of 1 (offset 0x04) removes the line from arbitration. The line's pending bit still latches.
- R8: An output with no eligible line is low, and its source register reads 0x00000000.
- R9: The revision register at offset 0xA8 reads the major revision in bits 7:4 and the minor revision in bits 3:0, with all upper bits 0. The defaults are 2 and 1, giving 0x00000021.
- R10: After reset, pending is 0, mask is 0xFFFFFFFF, all lines are in level mode, every configuration word is 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | 32 | Asynchronous interrupt request lines |
| bus_sel_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered, valid one cycle after the request |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
A line driven high before an edge is pending two edges later, and irq_o/fiq_o follow it right after that edge. The bench therefore waits three rising edges after it changes the lines and samples on the falling edge. Read data is registered, so every read is driven on a falling edge and sampled on the next falling edge. An acknowledge takes effect on the edge that captures the read data, so the output is checked on that same falling edge. Register writes complete on their single edge, and their effect is observed one falling edge later.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NUM_LINES = 32;
    localparam int PRIO_W    = 5;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int ROUTE_BIT = 8;

    localparam logic [ADDR_W-1:0] A_PEND     = 8'h00;
    localparam logic [ADDR_W-1:0] A_MASK     = 8'h04;
    localparam logic [ADDR_W-1:0] A_TRIG     = 8'h08;
    localparam logic [ADDR_W-1:0] A_SRC_IRQ  = 8'h10;
    localparam logic [ADDR_W-1:0] A_SRC_FIQ  = 8'h14;
    localparam logic [ADDR_W-1:0] A_CFG_BASE = 8'h20;
    localparam logic [ADDR_W-1:0] A_REV      = 8'hA8;

    typedef enum logic {
        OUT_IRQ = 1'b0,
        OUT_FIQ = 1'b1
    } out_sel_e;

    typedef struct packed {
        logic              route_fiq;
        logic [PRIO_W-1:0] prio;
    } line_cfg_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [DATA_W-1:0] src_word(pick_t p);
        logic [DATA_W-1:0] w;
        w = '0;
        if (p.valid) begin
            w[DATA_W-1]  = 1'b1;
            w[IDX_W-1:0] = p.idx;
        end
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(line_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PRIO_W-1:0] = c.prio;
        w[ROUTE_BIT]  = c.route_fiq;
        return w;
    endfunction

endpackage

// File: rtl/intc_sync_edge.sv
module intc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic edge_mode_i,
    output logic set_o
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], line_i};
            last_q <= sh_q[STAGES-1];
        end
    end

    assign set_o = edge_mode_i ? (sh_q[STAGES-1] & ~last_q) : sh_q[STAGES-1];

    // R2: an edge-mode line raises its set request for one cycle only
    a_r2_edge_single: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && set_o) |=> (!edge_mode_i || !set_o));

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic [NUM_LINES-1:0] elig_i,
    input  line_cfg_t cfg_i [NUM_LINES],
    output pick_t     pick_o
);
    always_comb begin
        logic [PRIO_W-1:0] best;
        best   = '1;
        pick_o = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (elig_i[i] && (!pick_o.valid || cfg_i[i].prio < best)) begin
                pick_o.valid = 1'b1;
                pick_o.idx   = IDX_W'(i);
                best         = cfg_i[i].prio;
            end
        end
    end

    // R8: nothing eligible means no valid winner
    a_r8_idle_no_pick: assert property (@(posedge clk) disable iff (rst)
        (elig_i == '0) |-> !pick_o.valid);

    a_r4_winner_eligible: assert property (@(posedge clk) disable iff (rst)
        pick_o.valid |-> elig_i[pick_o.idx]);

    for (genvar j = 0; j < NUM_LINES; j++) begin : g_chk
        // R4: no eligible line beats the winner on priority, or on index at a tie
        a_r4_no_better: assert property (@(posedge clk) disable iff (rst)
            (pick_o.valid && elig_i[j]) |->
                ((cfg_i[pick_o.idx].prio < cfg_i[j].prio) ||
                 ((cfg_i[pick_o.idx].prio == cfg_i[j].prio) && (pick_o.idx <= IDX_W'(j)))));
    end

endmodule

// File: rtl/intc_dual.sv
module intc_dual
    import intc_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] REV_MAJOR   = 4'd2,
    parameter logic [3:0] REV_MINOR   = 4'd1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_we_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic                 irq_o,
    output logic                 fiq_o
);
    localparam int NUM_OUT  = 2;
    localparam int CFG_SPAN = 4 * NUM_LINES;

    logic [NUM_LINES-1:0] pend_q, mask_q, trig_q, set_vec;
    line_cfg_t            cfg_q [NUM_LINES];
    logic [DATA_W-1:0]    rdata_q, rdata_d;
    pick_t                picks [NUM_OUT];
    logic [NUM_LINES-1:0] elig  [NUM_OUT];
    logic [NUM_LINES-1:0] route_vec;

    logic wr, rd, cfg_hit;
    logic [ADDR_W-1:0] cfg_off;
    logic [IDX_W-1:0]  cfg_idx;

    assign wr      = bus_sel_i & bus_we_i;
    assign rd      = bus_sel_i & ~bus_we_i;
    assign cfg_off = bus_addr_i - A_CFG_BASE;
    assign cfg_hit = (int'(cfg_off) < CFG_SPAN) && (cfg_off[1:0] == 2'b00);
    assign cfg_idx = cfg_off[IDX_W+1:2];

    // Input synchronizers and edge/level detection
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        intc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk         (clk),
            .rst         (rst),
            .line_i      (irq_lines_i[g]),
            .edge_mode_i (trig_q[g]),
            .set_o       (set_vec[g])
        );
        assign route_vec[g] = cfg_q[g].route_fiq;
    end

    // Per-output eligibility and arbitration
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        assign elig[o] = pend_q & ~mask_q &
                         ((o == int'(OUT_FIQ)) ? route_vec : ~route_vec);
        intc_arbiter u_arb (
            .clk    (clk),
            .rst    (rst),
            .elig_i (elig[o]),
            .cfg_i  (cfg_q),
            .pick_o (picks[o])
        );
    end

    // Clear sources: software write-0 and source-register acknowledge
    logic                 ack_irq, ack_fiq;
    logic [NUM_LINES-1:0] wclr, ackclr;

    assign ack_irq = rd && (bus_addr_i == A_SRC_IRQ) && picks[OUT_IRQ].valid;
    assign ack_fiq = rd && (bus_addr_i == A_SRC_FIQ) && picks[OUT_FIQ].valid;
    assign wclr    = (wr && bus_addr_i == A_PEND) ? ~bus_wdata_i : '0;

    always_comb begin
        ackclr = '0;
        if (ack_irq) ackclr[picks[OUT_IRQ].idx] = 1'b1;
        if (ack_fiq) ackclr[picks[OUT_FIQ].idx] = 1'b1;
    end

    always_comb begin
        rdata_d = '0;
        if (cfg_hit) begin
            rdata_d = cfg_word(cfg_q[cfg_idx]);
        end else begin
            case (bus_addr_i)
                A_PEND:    rdata_d = pend_q;
                A_MASK:    rdata_d = mask_q;
                A_TRIG:    rdata_d = trig_q;
                A_SRC_IRQ: rdata_d = src_word(picks[OUT_IRQ]);
                A_SRC_FIQ: rdata_d = src_word(picks[OUT_FIQ]);
                A_REV:     rdata_d = {{(DATA_W-8){1'b0}}, REV_MAJOR, REV_MINOR};
                default:   rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            mask_q  <= '1;
            trig_q  <= '0;
            rdata_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) cfg_q[i] <= '0;
        end else begin
            pend_q <= (pend_q & ~wclr & ~ackclr) | set_vec;
            if (wr && bus_addr_i == A_MASK) mask_q <= bus_wdata_i;
            if (wr && bus_addr_i == A_TRIG) trig_q <= bus_wdata_i;
            if (wr && cfg_hit) begin
                cfg_q[cfg_idx].prio      <= bus_wdata_i[PRIO_W-1:0];
                cfg_q[cfg_idx].route_fiq <= bus_wdata_i[ROUTE_BIT];
            end
            if (rd) rdata_q <= rdata_d;
        end
    end

    assign bus_rdata_o = rdata_q;
    assign irq_o       = picks[OUT_IRQ].valid;
    assign fiq_o       = picks[OUT_FIQ].valid;

    // R3: a write never raises a bit that was neither pending nor being set
    a_r3_w1_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr_i == A_PEND) |=> ((pend_q & ~$past(pend_q | set_vec)) == '0));

    // R3: bits written 0 end cleared unless hardware set them that cycle
    a_r3_w0_clears: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr_i == A_PEND) |=> ((pend_q & ~$past(bus_wdata_i) & ~$past(set_vec)) == '0));

    // R6: an acknowledged IRQ line is cleared unless set again
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_irq && !set_vec[picks[OUT_IRQ].idx]) |=> !pend_q[$past(picks[OUT_IRQ].idx)]);

    // R7: a masked line never wins either output
    a_r7_masked_out: assert property (@(posedge clk) disable iff (rst)
        (picks[OUT_IRQ].valid |-> !mask_q[picks[OUT_IRQ].idx]) and
        (picks[OUT_FIQ].valid |-> !mask_q[picks[OUT_FIQ].idx]));

    // R9: revision read returns the fixed identifier
    a_r9_rev_read: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr_i == A_REV) |=> (bus_rdata_o == {24'h0, REV_MAJOR, REV_MINOR}));

endmodule

// File: tb/intc_dual_bench.sv
`timescale 1ns/1ps
module intc_dual_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lines;
    logic        sel, we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq, fiq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    intc_dual u_intc_dual (
        .clk         (clk),
        .rst         (rst),
        .irq_lines_i (lines),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .fiq_o       (fiq)
    );

    // {lines, irq valid, irq idx, fiq valid, fiq idx}
    localparam int NV = 10;
    localparam logic [43:0] VEC [NV] = '{
        {32'h0000_0001, 1'b1, 5'd0,  1'b0, 5'd0 },
        {32'h0000_0006, 1'b1, 5'd2,  1'b0, 5'd0 },
        {32'h0000_0220, 1'b1, 5'd5,  1'b0, 5'd0 },
        {32'h0010_0200, 1'b1, 5'd20, 1'b0, 5'd0 },
        {32'h0000_0008, 1'b0, 5'd0,  1'b1, 5'd3 },
        {32'h0100_0408, 1'b1, 5'd10, 1'b1, 5'd24},
        {32'hC008_0000, 1'b1, 5'd19, 1'b1, 5'd31},
        {32'h0000_0000, 1'b0, 5'd0,  1'b0, 5'd0 },
        {32'hFFFF_FFFF, 1'b1, 5'd20, 1'b1, 5'd31},
        {32'h0004_0020, 1'b1, 5'd5,  1'b0, 5'd0 }
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        d = rdata;
    endtask

    function automatic logic [31:0] srcw(logic v, logic [4:0] i);
        return v ? {1'b1, 26'b0, i} : 32'h0;
    endfunction

    task automatic set_lines(logic [31:0] v);
        @(negedge clk);
        lines = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain();
        set_lines(32'h0);
        bus_wr(8'h00, 32'h0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; lines = '0; sel = 0; we = 0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        chk("R10 irq_o", {31'b0, irq}, 32'h0);
        chk("R10 fiq_o", {31'b0, fiq}, 32'h0);
        bus_rd(8'h04, r); chk("R10 mask", r, 32'hFFFF_FFFF);
        bus_rd(8'h00, r); chk("R10 pend", r, 32'h0);
        bus_rd(8'h08, r); chk("R10 trig", r, 32'h0);
        bus_rd(8'h20, r); chk("R10 cfg0", r, 32'h0);
        // R8 idle source registers
        bus_rd(8'h10, r); chk("R8 src irq idle", r, 32'h0);
        bus_rd(8'h14, r); chk("R8 src fiq idle", r, 32'h0);
        // R9 revision
        bus_rd(8'hA8, r); chk("R9 revision", r, 32'h0000_0021);

        // configuration: prio 31-n, ties at 5/9, urgent IRQ line 20, FIQ on 3 and 24..31
        for (int n = 0; n < 32; n++) begin
            logic [4:0] p;
            logic       f;
            p = 5'(31 - n);
            f = (n >= 24) || (n == 3);
            if (n == 5 || n == 9) p = 5'd2;
            if (n == 20) p = 5'd0;
            bus_wr(8'(32 + 4 * n), {23'b0, f, 3'b0, p});
        end
        bus_rd(8'h20 + 8'd12, r); chk("R5 cfg3 readback", r, 32'h0000_011C);
        bus_wr(8'h04, 32'h0);

        // Vector walk: R1 latency, R4 priority/tie, R5 routing, R6 source format, R8 idle
        for (int v = 0; v < NV; v++) begin
            logic [43:0] e;
            e = VEC[v];
            set_lines(e[43:12]);
            chk("R1 irq_o", {31'b0, irq}, {31'b0, e[11]});
            chk("R5 fiq_o", {31'b0, fiq}, {31'b0, e[5]});
            bus_rd(8'h10, r); chk("R4 src irq", r, srcw(e[11], e[10:6]));
            bus_rd(8'h14, r); chk("R6 src fiq", r, srcw(e[5], e[4:0]));
            drain();
        end

        // R7: masked lines still latch but do not arbitrate
        bus_wr(8'h04, 32'h8010_0000);
        set_lines(32'hFFFF_FFFF);
        bus_rd(8'h10, r); chk("R7 masked irq winner", r, srcw(1'b1, 5'd5));
        bus_rd(8'h14, r); chk("R7 masked fiq winner", r, srcw(1'b1, 5'd30));
        bus_rd(8'h00, r); chk("R7 masked still pending", r, 32'hFFFF_FFFF);
        drain();

        // R3: write 0 clears, write 1 keeps
        bus_wr(8'h04, 32'hFFFF_FFFF);
        set_lines(32'h0000_0050);
        set_lines(32'h0);
        bus_rd(8'h00, r); chk("R3 latched", r, 32'h0000_0050);
        bus_wr(8'h00, ~32'h0000_0010);
        bus_rd(8'h00, r); chk("R3 w0 clears w1 keeps", r, 32'h0000_0040);
        bus_wr(8'h00, 32'h0);
        bus_rd(8'h00, r); chk("R3 all cleared", r, 32'h0);

        // R3: set wins over a simultaneous clear
        set_lines(32'h0000_0080);
        bus_wr(8'h00, 32'h0);
        bus_rd(8'h00, r); chk("R3 set wins", r, 32'h0000_0080);
        drain();

        // R2 edge mode: acknowledge clears and input held high does not re-set
        bus_wr(8'h04, 32'h0);
        bus_wr(8'h08, 32'h0000_1000);
        set_lines(32'h0000_1000);
        chk("R2 edge irq up", {31'b0, irq}, 32'h1);
        bus_rd(8'h10, r); chk("R6 ack edge src", r, srcw(1'b1, 5'd12));
        chk("R6 irq after ack", {31'b0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        bus_rd(8'h00, r); chk("R2 edge stays clear", r, 32'h0);

        // R2 level mode: acknowledge is overridden while input high
        set_lines(32'h0000_3000);
        bus_rd(8'h10, r); chk("R2 level src", r, srcw(1'b1, 5'd13));
        bus_rd(8'h00, r); chk("R2 level re-sets", r, 32'h0000_2000);
        chk("R2 irq still up", {31'b0, irq}, 32'h1);
        drain();
        chk("R8 irq idle after drain", {31'b0, irq}, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule